// File: doc/BRIEF.md
# EDO DRAM Device Cycle Decoder

This block is the control core on the device side of a 16-bit wide EDO DRAM. It watches the active-low row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe, together with a multiplexed address bus. All strobes are sampled by a fast system clock. From the order of their edges it decides what each cycle is: a data access, a refresh of the row on the address bus, or a refresh that takes its row from an internal counter (column strobe before row strobe). It then drives a small register array that stands in for the cell matrix.

On an access it latches the row and column halves of the word address. It turns the two column strobes into one internal column strobe and one write enable per byte lane. It also decides, for each lane, whether the data pins drive read data or stay high-Z. The rules for that are the extended-data-out ones: read data is held after the column strobe rises, early writes keep the pins quiet, a late write is blocked while output enable is low, and a write-strobe pulse between accesses turns the outputs off.

Timing checks at nanosecond level and analog sensing are outside this block. Row and column widths are parameters, and their defaults are small enough for simulation.

Top module: `edo_cycle_decoder`

## Requirements
- R1: The two column strobes act as one internal strobe that goes active on the first lane to fall and inactive only when both are high again. The column address is captured only when the internal strobe goes active. A lane that falls or re-falls while the other lane holds the internal strobe low does not load a new column.
- R2: The row address is captured when the row strobe falls with both column strobes high. A later internal column strobe fall with the write strobe high starts a read, which drives the stored word of that row and column on `dq_out`. `cyc_kind` reports such a cycle as 1. Bit 0 of `dq_oe` enables lane 0 (bits 7:0) and bit 1 enables lane 1 (bits 15:8).
- R3: The low-lane strobe governs bits 7:0 and the high-lane strobe governs bits 15:8. A write with only one lane strobe low changes that byte and leaves the other byte of the word unchanged.
- R4: A row strobe fall while the internal column strobe is already low is a counter refresh. `cyc_kind` becomes 3, `rfsh_row` shows the current counter value, and the counter then advances by one, wrapping modulo 2^ROW_W.
- R5: A row strobe fall with the internal column strobe high and no column strobe afterwards is a row-only refresh. `cyc_kind` becomes 2 and `rfsh_row` shows the latched row. The refresh counter is not changed.
- R6: If the write strobe is low before the internal column strobe falls, that is an early write. The data on `dq_in` is stored and `dq_oe` stays 0 whatever the output-enable level.
- R7: If the write strobe falls after the column strobe with output enable high, that is a late write: the data on `dq_in` is stored into the lanes whose strobe is low. If output enable is low at that point, nothing is written and the read data stays driven.
- R8: Read data stays driven after the column strobes rise, for as long as the row strobe and output enable stay low. Once both the row strobe and the internal column strobe are high, `dq_oe` is 0.
- R9: A write-strobe fall while the internal column strobe is high turns `dq_oe` off. It stays off until a column strobe fall with the write strobe high.
- R10: While output enable is high `dq_oe` is 0. Taking it low again in the same read brings back the same data.
- R11: After reset `dq_oe` is 0, `cyc_kind` is 0 and the refresh counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Column strobe for lane 0 (bits 7:0), active low |
| cash_n | input | 1 | Column strobe for lane 1 (bits 15:8), active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 2*LANE_W | Write data from the pins |
| dq_out | output | 2*LANE_W | Read data toward the pins |
| dq_oe | output | 2 | Per-lane output drive enable |
| cyc_kind | output | 2 | Class of the last cycle: 0 none, 1 access, 2 row-only refresh, 3 counter refresh |
| rfsh_row | output | ROW_W | Row refreshed by the last refresh cycle |

## Verification
A strobe change passes two synchronizer flops and one edge register. The registered results (addresses, `cyc_kind`, `rfsh_row`, stored data, lane read state) therefore change on the third rising edge after the input moves. The output-enable gating of `dq_oe` follows after the second edge. The bench changes inputs only on falling edges. After every stimulus step it waits four rising edges and samples on the next falling edge, which is past every one of those delays and gives one cycle of margin. Address and write data are held through that whole window, so each check sees only the settled result of one step.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE   = 2'd0,
    KIND_ACCESS = 2'd1,
    KIND_RONLY  = 2'd2,
    KIND_CBR    = 2'd3
  } cyc_kind_e;

  // internal column strobe (active low): low when either lane is low
  function automatic logic cas_merge(input logic lo_n, input logic hi_n);
    return lo_n & hi_n;
  endfunction

  // lanes whose strobe is currently low, bit 0 = low lane
  function automatic logic [1:0] lanes_active(input logic lo_n, input logic hi_n);
    return {~hi_n, ~lo_n};
  endfunction

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      prev_q <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign fall[b] = prev_q[b] & ~lvl[b];
    assign rise[b] = ~prev_q[b] & lvl[b];
  end

endmodule

// File: rtl/edo_word_array.sv
module edo_word_array #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic [1:0]          wr_be,
  input  logic [ROW_W-1:0]    wr_row,
  input  logic [COL_W-1:0]    wr_col,
  input  logic [2*LANE_W-1:0] wr_data,
  input  logic [ROW_W-1:0]    rd_row,
  input  logic [COL_W-1:0]    rd_col,
  output logic [2*LANE_W-1:0] rd_data
);

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] word_index(input logic [ROW_W-1:0] r,
                                                  input logic [COL_W-1:0] c);
    return {r, c};
  endfunction

  logic [IDX_W-1:0] w_idx, r_idx;
  assign w_idx = word_index(wr_row, wr_col);
  assign r_idx = word_index(rd_row, rd_col);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_be[g]) cells[w_idx] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = cells[r_idx];
  end

endmodule

// File: rtl/edo_cycle_ctl.sv
module edo_cycle_ctl
  import edo_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_l,
  input  logic              casl_l,
  input  logic              cash_l,
  input  logic              we_l,
  input  logic              oe_l,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              casl_fall,
  input  logic              cash_fall,
  input  logic              we_fall,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [COL_W-1:0]  wr_col,
  output logic [1:0]        wr_be,
  output logic [1:0]        lane_oe,
  output cyc_kind_e         kind_q,
  output logic [ROW_W-1:0]  ref_row_q
);

  logic             cas_l;
  logic             cas_prev_q;
  logic             cas_fall_int;
  logic [1:0]       lane_fall;
  logic [1:0]       lanes_low;
  logic             cbr_q, acc_q, ewr_q;
  logic [1:0]       rd_q;
  logic [ROW_W-1:0] ref_ctr;

  // named internal events
  logic       cbr_start, row_start, access_start, late_evt;
  logic [1:0] early_lane, late_lane, read_join;

  assign cas_l        = cas_merge(casl_l, cash_l);
  assign cas_fall_int = cas_prev_q & ~cas_l;
  assign lane_fall    = {cash_fall, casl_fall};
  assign lanes_low    = lanes_active(casl_l, cash_l);

  assign cbr_start    = ras_fall & ~cas_l;
  assign row_start    = ras_fall & cas_l;
  assign access_start = cas_fall_int & ~ras_l & ~cbr_q;
  assign late_evt     = we_fall & ~ras_l & ~cbr_q & ~cas_l & acc_q;

  assign early_lane = lane_fall & {2{~ras_l & ~cbr_q & ~we_l}};
  assign late_lane  = (late_evt & oe_l) ? lanes_low : 2'b00;
  assign read_join  = lane_fall & {2{~ras_l & ~cbr_q & we_l & ~ewr_q}};

  assign wr_be   = early_lane | late_lane;
  assign wr_col  = access_start ? addr[COL_W-1:0] : col_q;
  assign lane_oe = rd_q & {2{~oe_l}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cas_prev_q <= 1'b1;
    else        cas_prev_q <= cas_l;
  end

  // cycle flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbr_q <= 1'b0;
      acc_q <= 1'b0;
      ewr_q <= 1'b0;
    end else if (ras_rise) begin
      cbr_q <= 1'b0;
      acc_q <= 1'b0;
      ewr_q <= 1'b0;
    end else begin
      if (cbr_start) cbr_q <= 1'b1;
      if (access_start) begin
        acc_q <= 1'b1;
        ewr_q <= ~we_l;
      end
    end
  end

  // address capture and classification
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      kind_q    <= KIND_IDLE;
      ref_row_q <= '0;
      ref_ctr   <= '0;
    end else begin
      if (cbr_start) begin
        kind_q    <= KIND_CBR;
        ref_row_q <= ref_ctr;
        ref_ctr   <= ref_ctr + 1'b1;
      end else if (row_start) begin
        kind_q    <= KIND_RONLY;
        row_q     <= addr[ROW_W-1:0];
        ref_row_q <= addr[ROW_W-1:0];
      end
      if (access_start) begin
        kind_q <= KIND_ACCESS;
        col_q  <= addr[COL_W-1:0];
      end
    end
  end

  // per-lane read drive state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rd_q <= 2'b00;
    else if (ras_l & cas_l)       rd_q <= 2'b00;
    else if (access_start)        rd_q <= we_l ? lanes_low : 2'b00;
    else if (we_fall & cas_l)     rd_q <= 2'b00;
    else if (late_evt & oe_l)     rd_q <= 2'b00;
    else                          rd_q <= rd_q | read_join;
  end

  assert_cbr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_start |=> (ref_ctr == ROW_W'($past(ref_ctr) + 1'b1)));

  assert_rowonly_keeps_ctr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |=> $stable(ref_ctr));

  assert_early_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ewr_q |-> (lane_oe == 2'b00));

  assert_late_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (late_evt && !oe_l) |-> (wr_be == 2'b00));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_l && cas_l) |=> (lane_oe == 2'b00));

  assert_we_pulse_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && cas_l) |=> (lane_oe == 2'b00));

endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
  import edo_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                casl_n,
  input  logic                cash_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic [1:0]          dq_oe,
  output logic [1:0]          cyc_kind,
  output logic [ROW_W-1:0]    rfsh_row
);

  localparam int NSTB = 5;

  logic [NSTB-1:0] s_lvl, s_fall, s_rise;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q, wr_col;
  logic [1:0]       wr_be;
  cyc_kind_e        kind_q;

  // bit order: 0 row, 1 low lane, 2 high lane, 3 write, 4 output enable
  edo_strobe_sync #(.W(NSTB), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({oe_n, we_n, cash_n, casl_n, ras_n}),
    .lvl  (s_lvl),
    .fall (s_fall),
    .rise (s_rise)
  );

  edo_cycle_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_l    (s_lvl[0]),
    .casl_l   (s_lvl[1]),
    .cash_l   (s_lvl[2]),
    .we_l     (s_lvl[3]),
    .oe_l     (s_lvl[4]),
    .ras_fall (s_fall[0]),
    .ras_rise (s_rise[0]),
    .casl_fall(s_fall[1]),
    .cash_fall(s_fall[2]),
    .we_fall  (s_fall[3]),
    .addr     (addr),
    .row_q    (row_q),
    .col_q    (col_q),
    .wr_col   (wr_col),
    .wr_be    (wr_be),
    .lane_oe  (dq_oe),
    .kind_q   (kind_q),
    .ref_row_q(rfsh_row)
  );

  edo_word_array #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .wr_be  (wr_be),
    .wr_row (row_q),
    .wr_col (wr_col),
    .wr_data(dq_in),
    .rd_row (row_q),
    .rd_col (col_q),
    .rd_data(dq_out)
  );

  assign cyc_kind = kind_q;

endmodule

// File: tb/edo_cycle_decoder_tb_top.sv
module edo_cycle_decoder_tb_top;

  localparam int ROW_W = 4, COL_W = 4, LANE_W = 8, ADDR_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic ras_n, casl_n, cash_n, we_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe, cyc_kind;
  logic [ROW_W-1:0] rfsh_row;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  edo_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_kind(cyc_kind), .rfsh_row(rfsh_row)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic open_row(input logic [3:0] r);
    addr = r; ras_n = 1'b0; settle();
  endtask

  task automatic close_all();
    casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; settle();
    ras_n = 1'b1; settle();
  endtask

  task automatic early_write(input logic [3:0] r, input logic [3:0] c,
                             input logic [15:0] d, input logic [1:0] lanes);
    open_row(r);
    we_n = 1'b0; settle();
    addr = c; dq_in = d; oe_n = 1'b0;
    casl_n = ~lanes[0]; cash_n = ~lanes[1]; settle();
    chk("R6 early write keeps DQ off with OE low", dq_oe, 2'b00);
    close_all();
  endtask

  task automatic read_word(input logic [3:0] r, input logic [3:0] c, output logic [15:0] d);
    open_row(r);
    addr = c; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; settle();
    chk("R2 read drives both lanes", dq_oe, 2'b11);
    d = dq_out;
    close_all();
  endtask

  task automatic t_reset();
    chk("R11 reset dq_oe", dq_oe, 2'b00);
    chk("R11 reset kind", cyc_kind, 2'd0);
    chk("R11 reset refresh row", rfsh_row, 4'd0);
  endtask

  task automatic t_writes();
    logic [15:0] d;
    early_write(4'd3, 4'd5, 16'hA5C3, 2'b11);
    early_write(4'd3, 4'd6, 16'h1234, 2'b11);
    read_word(4'd3, 4'd5, d);
    chk("R6 early word stored", d, 16'hA5C3);
    chk("R2 access kind", cyc_kind, 2'd1);
    early_write(4'd3, 4'd6, 16'hABCD, 2'b01);
    read_word(4'd3, 4'd6, d);
    chk("R3 low lane only", d, 16'h12CD);
    early_write(4'd3, 4'd6, 16'h9900, 2'b10);
    read_word(4'd3, 4'd6, d);
    chk("R3 high lane only", d, 16'h99CD);
  endtask

  task automatic t_cas_merge();
    open_row(4'd3);
    addr = 4'd6; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; settle();
    chk("R1 first lane drives only its byte", dq_oe, 2'b01);
    addr = 4'd5; cash_n = 1'b0; settle();
    chk("R1 second lane joins", dq_oe, 2'b11);
    chk("R1 second lane keeps first column", dq_out, 16'h99CD);
    casl_n = 1'b1; settle();
    casl_n = 1'b0; settle();
    chk("R1 re-fall under held strobe keeps column", dq_out, 16'h99CD);
    close_all();
  endtask

  task automatic t_late();
    logic [15:0] d;
    open_row(4'd3);
    addr = 4'd5; we_n = 1'b1; oe_n = 1'b1; casl_n = 1'b0; cash_n = 1'b0; settle();
    dq_in = 16'h5A5A; we_n = 1'b0; settle();
    close_all();
    read_word(4'd3, 4'd5, d);
    chk("R7 late write with OE high stores", d, 16'h5A5A);
    open_row(4'd3);
    addr = 4'd5; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; settle();
    dq_in = 16'hFFFF; we_n = 1'b0; settle();
    chk("R7 blocked late write still drives", dq_oe, 2'b11);
    chk("R7 blocked late write data", dq_out, 16'h5A5A);
    close_all();
    read_word(4'd3, 4'd5, d);
    chk("R7 blocked late write left word", d, 16'h5A5A);
  endtask

  task automatic t_edo_hold();
    open_row(4'd3);
    addr = 4'd5; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; settle();
    casl_n = 1'b1; cash_n = 1'b1; settle();
    chk("R8 hold after column strobe rise", dq_oe, 2'b11);
    chk("R8 held data", dq_out, 16'h5A5A);
    ras_n = 1'b1; settle();
    chk("R8 off after both strobes high", dq_oe, 2'b00);
    oe_n = 1'b1; settle();
  endtask

  task automatic t_oe();
    open_row(4'd3);
    addr = 4'd6; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; settle();
    oe_n = 1'b1; settle();
    chk("R10 OE high turns off", dq_oe, 2'b00);
    oe_n = 1'b0; settle();
    chk("R10 OE low restores drive", dq_oe, 2'b11);
    chk("R10 OE low restores data", dq_out, 16'h99CD);
    close_all();
  endtask

  task automatic t_we_pulse();
    open_row(4'd3);
    addr = 4'd5; we_n = 1'b1; oe_n = 1'b0; casl_n = 1'b0; cash_n = 1'b0; settle();
    casl_n = 1'b1; cash_n = 1'b1; settle();
    we_n = 1'b0; settle();
    we_n = 1'b1; settle();
    chk("R9 WE pulse turns off", dq_oe, 2'b00);
    addr = 4'd5; casl_n = 1'b0; cash_n = 1'b0; settle();
    chk("R9 read fall restores drive", dq_oe, 2'b11);
    chk("R9 pulse wrote nothing", dq_out, 16'h5A5A);
    close_all();
  endtask

  task automatic cbr(output logic [1:0] k, output logic [3:0] r);
    casl_n = 1'b0; cash_n = 1'b0; settle();
    ras_n = 1'b0; settle();
    k = cyc_kind; r = rfsh_row;
    casl_n = 1'b1; cash_n = 1'b1; settle();
    ras_n = 1'b1; settle();
  endtask

  task automatic t_refresh();
    logic [1:0] k;
    logic [3:0] r;
    cbr(k, r);
    chk("R4 counter refresh kind", k, 2'd3);
    chk("R4 first counter row", r, 4'd0);
    cbr(k, r);
    chk("R4 counter advanced", r, 4'd1);
    addr = 4'd9; ras_n = 1'b0; settle();
    chk("R5 row-only kind", cyc_kind, 2'd2);
    chk("R5 row-only row", rfsh_row, 4'd9);
    ras_n = 1'b1; settle();
    cbr(k, r);
    chk("R5 counter untouched by row-only", r, 4'd2);
    for (int i = 3; i < 16; i++) cbr(k, r);
    chk("R4 counter top", r, 4'd15);
    cbr(k, r);
    chk("R4 counter wraps", r, 4'd0);
  endtask

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; casl_n = 1'b1; cash_n = 1'b1;
    we_n = 1'b1; oe_n = 1'b1; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_writes();
    t_cas_merge();
    t_late();
    t_edo_hold();
    t_oe();
    t_we_pulse();
    t_refresh();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule